// File: doc/BRIEF.md
# Embedded-Sync Video Capture Filter

This block sits on an 8-bit parallel video input whose line and field timing is carried inside the data stream as four-byte timing codes. It finds those codes, keeps the field (F), vertical blanking (V) and horizontal blanking (H) state that they carry, and passes only the bytes chosen by a capture mode to an output byte stream marked by a valid strobe. Every byte the block forwards leaves it three clock cycles after it arrived. Gaps in the valid strobe show where bytes were dropped.

A timing code is the byte run 0xFF, 0x00, 0x00, T. In the T byte, bit 7 is always 1, bit 6 is F, bit 5 is V and bit 4 is H, where H=1 marks an end-of-line code and H=0 marks a start-of-line code. The block forwards nothing until it has found the start of field 1. That point is the first code with F=0 that comes after a code with F=1. The capture mode and the active-line quota are sampled only at that point, so software can change them at any time and the change applies from the next field-1 start.

The controller is a five-state machine:
- HUNT: after reset, waiting for a code with F=1. A code with F=1 moves it to PRIMED.
- PRIMED: a code with F=0 moves it to GAP. This sets the lock, samples the mode and quota, and clears the line count.
- GAP: locked, outside an active line.
  - In active mode, a start code with V=0 moves it to LINE and counts the line. If the quota is already used up, the same code moves it to SATED instead.
- LINE: an active line is open.
  - Another active start code is handled as it is in GAP.
  - Any other code closes the line, going to SATED if the quota is used up and to GAP otherwise.
- SATED: the quota is reached, and the block waits for the frame to end.
- From GAP, LINE or SATED, a field-1 start returns to GAP. This restarts the frame, samples the mode and quota again, and raises the end-of-frame pulse.

Top module: `vcap_filter`

## Requirements
- R1: The flags `fld`, `vblank` and `hblank` take bits 6, 5 and 4 of the T byte of a timing code (0xFF, 0x00, 0x00, T with T bit 7 = 1) on the clock edge at which T is sampled. They hold that value until the next code, and they update whether or not the block is locked.
- R2: A lone 0xFF data byte, or 0xFF followed by anything other than 0x00, 0x00 and a byte with bit 7 set, is not a code. In the run 0xFF, 0xFF, 0x00, 0x00, T, the second 0xFF begins a valid code.
- R3: `locked` rises on the edge that samples the first F=0 code after an F=1 code, and stays high until reset. While `locked` is low, no byte is forwarded.
- R4: A forwarded byte sampled at edge k appears on `pix_out`, with `pix_vld` high, after edge k+3.
- R5: Active mode (`cap_mode` = 2'b00) forwards only the bytes between a start code with V=0 and the next code. It never forwards code bytes, and after lock it forwards nothing until such a start code arrives.
- R6: In active mode, each start code with V=0 counts one line. Once `line_quota` lines have been taken in a frame, no further line is opened until the next field-1 start. A quota of 0 captures no line.
- R7: Vertical-blanking mode (2'b01) forwards non-code bytes while the most recent code had V=1.
- R8: Entire mode (2'b10) forwards every byte after the code that set the lock, code bytes included.
- R9: Mode 2'b11 forwards nothing.
- R10: `cap_mode` and `line_quota` are sampled only with the T byte of the lock code or of a later field-1 start. They govern bytes from the next byte on.
- R11: `sol` pulses for one cycle after the T byte of any start code with V=0 while locked. `eof` pulses for one cycle after the T byte of a field-1 start while already locked.
- R12: Reset clears the lock, the flags, the pulses and the output valid strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_in | input | 8 | Incoming video byte |
| cap_mode | input | 2 | Capture mode: 00 active, 01 vertical blanking, 10 entire, 11 off |
| line_quota | input | LINE_W | Active lines to capture per frame |
| pix_out | output | 8 | Forwarded byte |
| pix_vld | output | 1 | `pix_out` carries a forwarded byte |
| fld | output | 1 | F bit of the last code |
| vblank | output | 1 | V bit of the last code |
| hblank | output | 1 | H bit of the last code |
| sol | output | 1 | Start of an active line |
| eof | output | 1 | Frame ended at a field-1 start |
| locked | output | 1 | Field-1 start has been found |

## Verification
The bench goes after the boundaries of the code detector and of the lock:
- A stray 0xFF inside data, and 0xFF followed by only one 0x00, must pass as data. A detector that keyed on 0xFF alone would drop or mangle those bytes.
- A doubled 0xFF ahead of a code must still decode. A detector that did not restart would lose that code and its field change.
- F=0 codes that arrive before any F=1 code must not lock. A detector that locked on them would open capture a frame early.

It also targets the capture rules:
- A field with more active lines than the quota must stop at the quota.
- A quota of 0 must capture no line.
- A mode change written in the middle of a frame must wait for the next field-1 start. A design that sampled the mode at once would switch the stream halfway through.
- Entire mode must forward preambles, while active and blanking modes must drop all four code bytes. A design that squashed too few bytes would leak 0xFF or 0x00 into the stream.

A final reset while locked must drop the lock and require a new field-1 start.

// File: rtl/vcap_pkg.sv
package vcap_pkg;
    localparam int BYTE_W = 8;
    // bytes of a timing code that come before the T byte
    localparam int HIST_N = 3;
    localparam int F_BIT  = 6;
    localparam int V_BIT  = 5;
    localparam int H_BIT  = 4;
    localparam logic [BYTE_W-1:0] PRE_HI = 8'hFF;
    localparam logic [BYTE_W-1:0] PRE_LO = 8'h00;

    typedef enum logic [1:0] {
        CAP_ACTIVE = 2'b00,
        CAP_VBLANK = 2'b01,
        CAP_WHOLE  = 2'b10,
        CAP_OFF    = 2'b11
    } cap_mode_t;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_PRIMED,
        ST_GAP,
        ST_LINE,
        ST_SATED
    } cap_state_t;

    typedef struct packed {
        logic f;
        logic v;
        logic h;
    } tflags_t;

    typedef struct packed {
        logic              keep;
        logic [BYTE_W-1:0] data;
    } slot_t;
endpackage

// File: rtl/vcap_code_det.sv
module vcap_code_det
    import vcap_pkg::*;
(
    input  logic [HIST_N-1:0][BYTE_W-1:0] hist,
    input  logic [BYTE_W-1:0]             cur,
    output logic                          hit,
    output tflags_t                       xy
);
    // hist[0] is the newest byte; the oldest must be the high marker
    always_comb begin
        hit = cur[BYTE_W-1];
        for (int i = 0; i < HIST_N; i++) begin
            if (i == HIST_N - 1) begin
                hit = hit & (hist[i] == PRE_HI);
            end else begin
                hit = hit & (hist[i] == PRE_LO);
            end
        end
        xy.f = cur[F_BIT];
        xy.v = cur[V_BIT];
        xy.h = cur[H_BIT];
    end
endmodule

// File: rtl/vcap_delay.sv
module vcap_delay
    import vcap_pkg::*;
#(
    parameter int DEPTH = HIST_N
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [BYTE_W-1:0]            din,
    input  logic                         keep_in,
    input  logic                         squash,
    output logic [DEPTH-1:0][BYTE_W-1:0] hist,
    output logic [BYTE_W-1:0]            dout,
    output logic                         dout_vld
);
    slot_t stg [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                stg[i] <= '0;
            end
            dout     <= '0;
            dout_vld <= 1'b0;
        end else begin
            stg[0].keep <= keep_in;
            stg[0].data <= din;
            for (int i = 1; i < DEPTH; i++) begin
                stg[i].keep <= stg[i-1].keep & ~squash;
                stg[i].data <= stg[i-1].data;
            end
            dout     <= stg[DEPTH-1].data;
            dout_vld <= stg[DEPTH-1].keep & ~squash;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_tap
        assign hist[g] = stg[g].data;
    end
endmodule

// File: rtl/vcap_ctrl.sv
module vcap_ctrl
    import vcap_pkg::*;
#(
    parameter int LINE_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  tflags_t           xy,
    input  logic [1:0]        mode_sel,
    input  logic [LINE_W-1:0] line_quota,
    output logic              keep_in,
    output logic              squash,
    output logic              locked,
    output logic              fld,
    output logic              vblank,
    output logic              hblank,
    output logic              sol,
    output logic              eof
);
    cap_state_t        st_q, st_d;
    cap_mode_t         mode_q, mode_d;
    logic [LINE_W-1:0] quota_q, quota_d, taken_q, taken_d;
    logic              last_f_q;
    logic              run_now, f1_hit, sav_act;

    assign run_now = (st_q == ST_GAP) || (st_q == ST_LINE) || (st_q == ST_SATED);
    assign f1_hit  = hit & ~xy.f & last_f_q;
    assign sav_act = hit & ~xy.h & ~xy.v;

    // next-state logic
    always_comb begin
        st_d    = st_q;
        mode_d  = mode_q;
        quota_d = quota_q;
        taken_d = taken_q;
        unique case (st_q)
            ST_HUNT: begin
                if (hit && xy.f) st_d = ST_PRIMED;
            end
            ST_PRIMED: begin
                if (hit && !xy.f) begin
                    st_d    = ST_GAP;
                    mode_d  = cap_mode_t'(mode_sel);
                    quota_d = line_quota;
                    taken_d = '0;
                end
            end
            ST_GAP, ST_LINE: begin
                if (f1_hit) begin
                    st_d    = ST_GAP;
                    mode_d  = cap_mode_t'(mode_sel);
                    quota_d = line_quota;
                    taken_d = '0;
                end else if (mode_q == CAP_ACTIVE && sav_act) begin
                    if (taken_q == quota_q) begin
                        st_d = ST_SATED;
                    end else begin
                        st_d    = ST_LINE;
                        taken_d = taken_q + 1'b1;
                    end
                end else if (st_q == ST_LINE && hit) begin
                    st_d = (taken_q == quota_q) ? ST_SATED : ST_GAP;
                end
            end
            ST_SATED: begin
                if (f1_hit) begin
                    st_d    = ST_GAP;
                    mode_d  = cap_mode_t'(mode_sel);
                    quota_d = line_quota;
                    taken_d = '0;
                end
            end
            default: st_d = ST_HUNT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= ST_HUNT;
            mode_q   <= CAP_OFF;
            quota_q  <= '0;
            taken_q  <= '0;
            last_f_q <= 1'b0;
            fld      <= 1'b0;
            vblank   <= 1'b0;
            hblank   <= 1'b0;
            sol      <= 1'b0;
            eof      <= 1'b0;
        end else begin
            st_q    <= st_d;
            mode_q  <= mode_d;
            quota_q <= quota_d;
            taken_q <= taken_d;
            sol     <= run_now & sav_act;
            eof     <= run_now & f1_hit;
            if (hit) begin
                last_f_q <= xy.f;
                fld      <= xy.f;
                vblank   <= xy.v;
                hblank   <= xy.h;
            end
        end
    end

    // per-byte output decisions
    always_comb begin
        unique case (mode_q)
            CAP_WHOLE:  keep_in = run_now;
            CAP_VBLANK: keep_in = run_now & vblank & ~hit;
            CAP_ACTIVE: keep_in = (st_q == ST_LINE) & ~hit;
            default:    keep_in = 1'b0;
        endcase
        squash = hit & ~(run_now & (mode_q == CAP_WHOLE));
        locked = run_now;
    end

    // R3
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_now |=> run_now);
    // R3
    lock_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_now) |-> ($past(hit) && !$past(xy.f) && $past(last_f_q)));
    // R6
    quota_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        taken_q <= quota_q);
    // R5
    line_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_LINE) |-> (mode_q == CAP_ACTIVE));
    // R11
    eof_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eof |-> run_now);
endmodule

// File: rtl/vcap_filter.sv
module vcap_filter
    import vcap_pkg::*;
#(
    parameter int LINE_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        pix_in,
    input  logic [1:0]        cap_mode,
    input  logic [LINE_W-1:0] line_quota,
    output logic [7:0]        pix_out,
    output logic              pix_vld,
    output logic              fld,
    output logic              vblank,
    output logic              hblank,
    output logic              sol,
    output logic              eof,
    output logic              locked
);
    logic [HIST_N-1:0][BYTE_W-1:0] hist;
    logic                          hit, keep_in, squash;
    tflags_t                       xy;

    vcap_code_det u_det (
        .hist (hist),
        .cur  (pix_in),
        .hit  (hit),
        .xy   (xy)
    );

    vcap_ctrl #(.LINE_W(LINE_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit        (hit),
        .xy         (xy),
        .mode_sel   (cap_mode),
        .line_quota (line_quota),
        .keep_in    (keep_in),
        .squash     (squash),
        .locked     (locked),
        .fld        (fld),
        .vblank     (vblank),
        .hblank     (hblank),
        .sol        (sol),
        .eof        (eof)
    );

    vcap_delay #(.DEPTH(HIST_N)) u_dly (
        .clk      (clk),
        .rst_n    (rst_n),
        .din      (pix_in),
        .keep_in  (keep_in),
        .squash   (squash),
        .hist     (hist),
        .dout     (pix_out),
        .dout_vld (pix_vld)
    );

    // R3
    vld_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_vld |-> locked);
endmodule

// File: tb/vcap_filter_tb.sv
module vcap_filter_tb;
    localparam int LW   = 11;
    localparam int MAXN = 4096;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    din = 8'h10;
    logic [1:0]    msel = 2'b00;
    logic [LW-1:0] quota = '0;
    logic [7:0]    pix_out;
    logic          pix_vld, fld, vblank, hblank, sol, eof, locked;

    vcap_filter #(.LINE_W(LW)) u_dut (
        .clk(clk), .rst_n(rst_n), .pix_in(din), .cap_mode(msel), .line_quota(quota),
        .pix_out(pix_out), .pix_vld(pix_vld), .fld(fld), .vblank(vblank),
        .hblank(hblank), .sol(sol), .eof(eof), .locked(locked)
    );

    always #5 clk = ~clk;

    logic [7:0]    s_dat [MAXN];
    logic [1:0]    s_md  [MAXN];
    logic [LW-1:0] s_qt  [MAXN];
    string         s_tag [MAXN];
    bit e_keep [MAXN];
    bit e_lock [MAXN];
    bit e_sol  [MAXN];
    bit e_eof  [MAXN];
    bit [2:0] e_fvh [MAXN];

    int n = 0;
    int vectors = 0;
    int errs = 0;
    int pixseed = 0;
    bit done = 0;
    logic [1:0]    g_md = 2'b00;
    logic [LW-1:0] g_qt = '0;
    string         g_tag = "R3";

    task automatic put(input logic [7:0] b);
        s_dat[n] = b; s_md[n] = g_md; s_qt[n] = g_qt; s_tag[n] = g_tag;
        n++;
    endtask

    task automatic tcode(input bit f, input bit v, input bit h);
        put(8'hFF); put(8'h00); put(8'h00); put({1'b1, f, v, h, 4'b0101});
    endtask

    task automatic tline(input bit f, input bit v, input int npix);
        tcode(f, v, 1'b1);
        put(8'h80); put(8'h10); put(8'h80); put(8'h10);
        tcode(f, v, 1'b0);
        for (int i = 0; i < npix; i++) begin
            put(8'h01 + 8'(pixseed % 254));
            pixseed++;
        end
    endtask

    task automatic tfield(input bit f, input int nvb, input int nact);
        for (int i = 0; i < nvb; i++) tline(f, 1'b1, 5);
        for (int i = 0; i < nact; i++) tline(f, 1'b0, 6);
    endtask

    // behavioural reference: walks the byte list once
    task automatic run_model();
        int phase = 0;
        int taken = 0;
        int cm = 0;
        int cq = 0;
        bit inl = 0, sat = 0, lf = 0;
        bit [2:0] fvh = 3'b000;
        for (int i = 0; i < n; i++) begin
            bit code, run, f, v, h, f1;
            code = (i >= 3) && s_dat[i-3] == 8'hFF && s_dat[i-2] == 8'h00
                   && s_dat[i-1] == 8'h00 && s_dat[i][7];
            run = (phase == 2);
            case (cm)
                2: e_keep[i] = run;
                1: e_keep[i] = run && fvh[1] && !code;
                0: e_keep[i] = run && inl && !code;
                default: e_keep[i] = 1'b0;
            endcase
            e_sol[i] = 1'b0;
            e_eof[i] = 1'b0;
            if (code) begin
                f = s_dat[i][6]; v = s_dat[i][5]; h = s_dat[i][4];
                f1 = !f && lf;
                if (!(run && cm == 2)) begin
                    for (int j = 1; j <= 3; j++) e_keep[i-j] = 1'b0;
                end
                e_sol[i] = run && !h && !v;
                e_eof[i] = run && f1;
                if (phase == 0) begin
                    if (f) phase = 1;
                end else if (phase == 1) begin
                    if (!f) begin
                        phase = 2; cm = int'(s_md[i]); cq = int'(s_qt[i]);
                        taken = 0; inl = 0; sat = 0;
                    end
                end else if (f1) begin
                    cm = int'(s_md[i]); cq = int'(s_qt[i]);
                    taken = 0; inl = 0; sat = 0;
                end else if (cm == 0 && !sat) begin
                    if (!h && !v) begin
                        if (taken == cq) begin sat = 1; inl = 0; end
                        else begin inl = 1; taken++; end
                    end else if (inl) begin
                        inl = 0;
                        if (taken == cq) sat = 1;
                    end
                end
                lf = f;
                fvh = {f, v, h};
            end
            e_lock[i] = (phase == 2);
            e_fvh[i] = fvh;
        end
    endtask

    task automatic chk(input bit ok, input string what, input string region,
                       input int act, input int exp);
        vectors++;
        if (!ok) begin
            errs++;
            $display("FAIL %s [region %s] got %0h expected %0h at t=%0t",
                     what, region, act, exp, $time);
        end
    endtask

    // outputs after the edge that sampled byte k
    task automatic check_at(input int k);
        bit ev;
        ev = (k >= 3) ? e_keep[k-3] : 1'b0;
        chk(pix_vld === ev, "R4 pix_vld", (k >= 3) ? s_tag[k-3] : s_tag[k],
            int'(pix_vld), int'(ev));
        if (ev && pix_vld === 1'b1)
            chk(pix_out === s_dat[k-3], "R4 pix_out", s_tag[k-3],
                int'(pix_out), int'(s_dat[k-3]));
        chk(locked === e_lock[k], "R3 locked", s_tag[k], int'(locked), int'(e_lock[k]));
        chk({fld, vblank, hblank} === e_fvh[k], "R1 flags", s_tag[k],
            int'({fld, vblank, hblank}), int'(e_fvh[k]));
        chk(sol === e_sol[k], "R11 sol", s_tag[k], int'(sol), int'(e_sol[k]));
        chk(eof === e_eof[k], "R11 eof", s_tag[k], int'(eof), int'(e_eof[k]));
    endtask

    task automatic run_stream();
        run_model();
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (k > 0) check_at(k - 1);
            din = s_dat[k]; msel = s_md[k]; quota = s_qt[k];
        end
        @(negedge clk);
        check_at(n - 1);
    endtask

    task automatic check_reset();
        chk(locked === 1'b0, "R12 locked", "R12", int'(locked), 0);
        chk(pix_vld === 1'b0, "R12 pix_vld", "R12", int'(pix_vld), 0);
        chk({fld, vblank, hblank, sol, eof} === 5'b0, "R12 flags", "R12",
            int'({fld, vblank, hblank, sol, eof}), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_reset();
        rst_n = 1'b1;

        // segment one
        n = 0;
        g_md = 2'b00; g_qt = 11'd2; g_tag = "R3";
        put(8'h55); put(8'hFF); put(8'h12); put(8'hFF); put(8'h00); put(8'h21);
        tfield(1'b0, 1, 1);
        g_tag = "R2";
        put(8'hFF);
        tcode(1'b1, 1'b1, 1'b1);
        g_tag = "R3";
        tfield(1'b1, 1, 2);
        g_tag = "R5";
        tfield(1'b0, 2, 3);
        tfield(1'b1, 1, 1);
        g_tag = "R2";
        tcode(1'b0, 1'b0, 0);
        put(8'hFF); put(8'h00); put(8'h33); put(8'hFF); put(8'h44);
        put(8'hFF); put(8'h00); put(8'h00); put(8'h45);
        put(8'hFF);
        tcode(1'b0, 1'b0, 1'b1);
        g_tag = "R10";
        g_md = 2'b01; g_qt = 11'd0;
        tline(1'b0, 1'b0, 4);
        tfield(1'b1, 1, 1);
        g_tag = "R7";
        tfield(1'b0, 2, 2);
        g_tag = "R10";
        g_md = 2'b10;
        tfield(1'b1, 1, 1);
        g_tag = "R8";
        tfield(1'b0, 1, 1);
        tfield(1'b1, 1, 1);
        g_tag = "R9";
        g_md = 2'b11;
        tfield(1'b0, 1, 1);
        tfield(1'b1, 1, 1);
        g_tag = "R6";
        g_md = 2'b00; g_qt = 11'd0;
        tfield(1'b0, 1, 2);
        g_qt = 11'd1;
        tfield(1'b1, 1, 1);
        tfield(1'b0, 1, 3);
        tfield(1'b1, 1, 1);
        tcode(1'b0, 1'b1, 1'b1);
        repeat (4) put(8'h10);
        run_stream();

        // reset while locked
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check_reset();
        rst_n = 1'b1;

        // segment two: lock must be found again
        n = 0;
        g_tag = "R12"; g_md = 2'b10; g_qt = 11'd1;
        tfield(1'b0, 1, 2);
        tfield(1'b1, 1, 1);
        tfield(1'b0, 1, 1);
        repeat (4) put(8'h10);
        run_stream();

        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1;
            errs++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
            $finish;
        end
    end
endmodule